// File: doc/BRIEF.md
# Edge-Qualified Delayed Trip Event

This block turns a comparator trip indication into a filtered and optionally delayed trip event. One output channel can then react to the raw comparator event at once, while a second channel, driven by this block's output, reacts a programmed number of clock cycles later from the same input. Several compare events feed the block, and a select input picks one of them. An edge-polarity bit picks which transition of that event counts. An edge-count setting says how many such transitions must be seen before the filter fires. Once the count is met, a delay counter on the module clock starts. When it expires, a single-cycle pulse appears on the output. The delay is the programmed value, optionally divided by a power of two.

Each compare event has a high-side and a low-side comparator input. The event is active while its high-side input is low, and the low-side input plays no part. The block has no data stream, so every pin is a plain level. There is no valid/ready pair and no back-pressure. Configuration inputs are expected to change only while reset is held. A change of the source select at any other time is seen as a transition of the selected event. All state is cleared by a synchronous, active-high reset.

Top module: `trip_delay_filter`

## Requirements
- R1: `src_sel` picks the watched event by index. Code 3 picks event 3, the second event of the B-side pair. Transitions on any other event have no effect on the output.
- R2: When `edge_fall` = 0, a qualifying edge is the event going from inactive to active. When `edge_fall` = 1, it is the event going from active to inactive. Event i is active while `cmp_hi[i]` = 0.
- R3: With `edge_count` = N, the filter fires on the (N+1)th qualifying edge, so N = 0 fires on the first. No pulse appears before that edge. The edge tally then restarts from zero.
- R4: With `dly_en` = 0, `filt_evt` pulses in the cycle that follows the clock edge that samples the firing edge.
- R5: With `dly_en` = 1 and `dly_div` = 0, the pulse comes exactly `dly_val` cycles later than in R4. A value of 0 gives the R4 timing.
- R6: `dly_div` codes 1, 2 and 3 shift `dly_val` right by 1, 2 and 3 bits before it sets the delay of R5.
- R7: Qualifying edges that arrive while a delay is running are ignored and not counted. Counting resumes after the pulse.
- R8: A synchronous reset clears the edge tally, the delay counter and `filt_evt`. The first cycle after reset never sees an edge, whatever level the event holds.
- R9: `cmp_lo` has no effect on `filt_evt`.
- R10: Every firing gives exactly one `filt_evt` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; the delay is counted in its cycles |
| srst | input | 1 | Synchronous reset, active high |
| cmp_hi | input | NUM_SRC | High-side comparator input per event; an event is active while its bit is 0 |
| cmp_lo | input | NUM_SRC | Low-side comparator input per event; ignored |
| src_sel | input | SEL_W | Index of the watched event |
| edge_fall | input | 1 | 0: inactive-to-active edges qualify; 1: active-to-inactive edges qualify |
| edge_count | input | CNT_W | Number of extra qualifying edges required before firing |
| dly_en | input | 1 | 1 applies the programmed delay; 0 fires without delay |
| dly_div | input | DIV_W | Right-shift applied to the delay value |
| dly_val | input | DLY_W | Delay in clock cycles before division |
| filt_evt | output | 1 | One-cycle filtered, delayed trip pulse |

## Verification
The bench sweeps every source, both polarities, edge counts 0 to 2, both delay settings, all divider codes and delays of 0, 1, 5 and 13. For each case it measures the exact cycle of the single pulse. During the wait it toggles the low-side inputs and the unselected high-side inputs. A design that counted the wrong transition would pulse one cycle late. An off-by-one counter or a wrong shift would shift the pulse. A design with leaky source selection would pulse twice or early. A dedicated sequence sends edges while a delay is running. It then checks that they neither restart the delay nor get counted, so a design that counted them would fire on the next lone edge. A reset taken with the event already active must not produce a pulse, which catches a design whose edge detector starts from a fixed level.

// File: rtl/trip_dly_pkg.sv
package trip_dly_pkg;

  // Divider code applied to the programmed delay value.
  typedef enum logic [1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY4 = 2'd2,
    DIV_BY8 = 2'd3
  } dly_div_e;

  // Qualifying transition of the watched event.
  typedef enum logic {
    EDGE_ASSERT   = 1'b0,
    EDGE_DEASSERT = 1'b1
  } edge_pol_e;

endpackage

// File: rtl/tde_edge_qual.sv
module tde_edge_qual
  import trip_dly_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               srst,
  input  logic [NUM_SRC-1:0] cmp_hi,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               edge_fall,
  input  logic [CNT_W-1:0]   edge_count,
  input  logic               hold,
  output logic               qual
);

  // Event i is active while its high-side comparator input is low.
  logic [NUM_SRC-1:0] evt;
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_evt
      assign evt[gi] = ~cmp_hi[gi];
    end
  endgenerate

  logic             sel_evt;
  logic             evt_q;
  logic             armed;
  logic [CNT_W-1:0] ecnt;
  logic             went_up;
  logic             went_down;
  logic             hit;
  logic             accept;
  edge_pol_e        pol;

  assign sel_evt   = evt[src_sel];
  assign pol       = edge_pol_e'(edge_fall);
  assign went_up   = sel_evt & ~evt_q;
  assign went_down = ~sel_evt & evt_q;
  assign hit       = armed & ((pol == EDGE_DEASSERT) ? went_down : went_up);
  assign accept    = hit & ~hold;
  assign qual      = accept & (ecnt >= edge_count);

  always_ff @(posedge clk) begin
    evt_q <= sel_evt;
    if (srst) begin
      armed <= 1'b0;
      ecnt  <= '0;
    end else begin
      armed <= 1'b1;
      if (accept) begin
        ecnt <= qual ? '0 : CNT_W'(ecnt + 1'b1);
      end
    end
  end

  // R7: while the delay runs, the edge tally does not move.
  p_hold_freezes_r7: assert property (@(posedge clk) disable iff (srst)
    (hold && !srst) |=> $stable(ecnt));

  // R3: the tally never passes the programmed count (config is static outside reset).
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (srst)
    ecnt <= edge_count);

  // R8: nothing qualifies in the first cycle after reset.
  p_no_edge_after_reset_r8: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> !qual);

endmodule

// File: rtl/tde_delay_timer.sv
module tde_delay_timer
  import trip_dly_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             start,
  input  logic             dly_en,
  input  logic [DIV_W-1:0] dly_div,
  input  logic [DLY_W-1:0] dly_val,
  output logic             busy,
  output logic             fire
);

  logic [DLY_W-1:0] scaled;
  logic [DLY_W-1:0] load_val;
  logic [DLY_W-1:0] cnt;

  assign scaled   = dly_val >> dly_div;
  assign load_val = dly_en ? scaled : '0;

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt  <= '0;
      busy <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (busy) begin
        if (cnt == DLY_W'(1)) begin
          fire <= 1'b1;
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        if (load_val == '0) begin
          fire <= 1'b1;
        end else begin
          cnt  <= load_val;
          busy <= 1'b1;
        end
      end
    end
  end

  // R5: a running delay always holds a non-zero remaining count.
  p_busy_nonzero_r5: assert property (@(posedge clk) disable iff (srst)
    busy |-> (cnt != '0));

  // R5: the remaining count falls by one each cycle until the last.
  p_countdown_r5: assert property (@(posedge clk) disable iff (srst)
    (busy && !srst && cnt > DLY_W'(1)) |=> (busy && cnt == $past(cnt) - 1'b1));

  // R6: a start with a non-zero scaled delay opens a delay window.
  p_start_loads_r6: assert property (@(posedge clk) disable iff (srst)
    (start && !busy && !srst && dly_en && scaled != '0) |=> busy);

endmodule

// File: rtl/trip_delay_filter.sv
module trip_delay_filter
  import trip_dly_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int CNT_W   = 3,
  parameter int DLY_W   = 16,
  parameter int DIV_W   = 2
) (
  input  logic               clk,
  input  logic               srst,
  input  logic [NUM_SRC-1:0] cmp_hi,
  input  logic [NUM_SRC-1:0] cmp_lo,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               edge_fall,
  input  logic [CNT_W-1:0]   edge_count,
  input  logic               dly_en,
  input  logic [DIV_W-1:0]   dly_div,
  input  logic [DLY_W-1:0]   dly_val,
  output logic               filt_evt
);

  logic qual;
  logic busy;

  tde_edge_qual #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W),
    .CNT_W   (CNT_W)
  ) u_qual (
    .clk        (clk),
    .srst       (srst),
    .cmp_hi     (cmp_hi),
    .src_sel    (src_sel),
    .edge_fall  (edge_fall),
    .edge_count (edge_count),
    .hold       (busy),
    .qual       (qual)
  );

  tde_delay_timer #(
    .DLY_W (DLY_W),
    .DIV_W (DIV_W)
  ) u_timer (
    .clk     (clk),
    .srst    (srst),
    .start   (qual),
    .dly_en  (dly_en),
    .dly_div (dly_div),
    .dly_val (dly_val),
    .busy    (busy),
    .fire    (filt_evt)
  );

  // R10: a pulse never lasts more than one cycle.
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (srst)
    filt_evt |=> !filt_evt);

  // R4: with the delay off, a firing edge reaches the output on the next cycle.
  p_direct_path_r4: assert property (@(posedge clk) disable iff (srst)
    (!dly_en && qual && !srst) |=> filt_evt);

  // R9: movement on the low-side inputs alone never creates a qualifying edge.
  p_lo_inert_r9: assert property (@(posedge clk) disable iff (srst)
    (!$stable(cmp_lo) && $stable(cmp_hi) && $stable(src_sel)) |-> !qual);

  // R8: the output and the delay are clear right after reset.
  p_reset_clears_r8: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> (!filt_evt && !busy));

endmodule

// File: tb/sim_trip_delay_filter.sv
`timescale 1ns/1ps
module sim_trip_delay_filter;

  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic [3:0]  cmp_hi = 4'hF;
  logic [3:0]  cmp_lo = 4'h0;
  logic [1:0]  src_sel = 2'd0;
  logic        edge_fall = 1'b0;
  logic [2:0]  edge_count = 3'd0;
  logic        dly_en = 1'b0;
  logic [1:0]  dly_div = 2'd0;
  logic [15:0] dly_val = 16'd0;
  logic        filt_evt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  trip_delay_filter u0 (
    .clk(clk), .srst(srst), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .src_sel(src_sel), .edge_fall(edge_fall), .edge_count(edge_count),
    .dly_en(dly_en), .dly_div(dly_div), .dly_val(dly_val),
    .filt_evt(filt_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Reset with the selected event at level lvl_hi; config already set.
  task automatic do_reset(input int s, input logic lvl_hi);
    srst = 1'b1;
    cmp_hi = edge_fall ? 4'h0 : 4'hF;
    cmp_hi[s] = lvl_hi;
    repeat (2) @(negedge clk);
    chk(filt_evt == 1'b0, "R8 output low in reset", filt_evt, 0);
    srst = 1'b0;
    @(negedge clk);
  endtask

  // One qualifying edge and its return; counts pulses seen in its two cycles.
  task automatic do_edge(input int s, input logic b, inout int seen);
    cmp_hi[s] = ~b;
    @(negedge clk);
    seen += filt_evt;
    cmp_hi[s] = b;
    @(negedge clk);
    seen += filt_evt;
  endtask

  task automatic idle(input int k, inout int seen);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      seen += filt_evt;
    end
  endtask

  task automatic run_case(input int s, input int f, input int n,
                          input int en, input int dv, input int val);
    logic b;
    int d, early, first, pulses;
    logic [3:0] noise;
    src_sel = 2'(s); edge_fall = f[0]; edge_count = 3'(n);
    dly_en = en[0]; dly_div = 2'(dv); dly_val = 16'(val);
    b = f[0] ? 1'b0 : 1'b1;
    d = en ? (val >> dv) : 0;
    do_reset(s, b);
    early = 0;
    for (int e = 0; e < n; e++) do_edge(s, b, early);
    if (n > 0) chk(early == 0, "R3 no pulse before last edge", early, 0);
    noise = ~(4'b0001 << s);
    cmp_hi[s] = ~b;
    first = 0; pulses = 0;
    for (int j = 1; j <= d + 8; j++) begin
      @(negedge clk);
      if (filt_evt) begin
        pulses++;
        if (first == 0) first = j;
      end
      if (j == 1) cmp_hi[s] = b;
      cmp_lo = ~cmp_lo;           // R9 stimulus
      cmp_hi = cmp_hi ^ noise;    // R1 stimulus on unselected events
    end
    if (!en)      chk(first == d + 1, "R2 R4 pulse cycle", first, d + 1);
    else if (dv == 0) chk(first == d + 1, "R2 R5 pulse cycle", first, d + 1);
    else          chk(first == d + 1, "R2 R6 pulse cycle", first, d + 1);
    chk(pulses == 1, "R10 R9 R1 single pulse", pulses, 1);
  endtask

  initial begin
    int seen;
    int vals[4] = '{0, 1, 5, 13};

    // R8: reset with the event already at its post-edge level.
    src_sel = 2'd2; edge_fall = 1'b0; edge_count = 3'd0;
    dly_en = 1'b0; dly_div = 2'd0; dly_val = 16'd0;
    do_reset(2, 1'b0);
    seen = 0;
    idle(5, seen);
    chk(seen == 0, "R8 no edge seen after reset", seen, 0);

    // R1: select code 3, edges on event 0 must do nothing, then event 3 fires.
    src_sel = 2'd3;
    do_reset(3, 1'b1);
    seen = 0;
    do_edge(0, 1'b1, seen);
    idle(4, seen);
    chk(seen == 0, "R1 unselected event ignored", seen, 0);
    seen = 0;
    do_edge(3, 1'b1, seen);
    idle(2, seen);
    chk(seen == 1, "R1 code 3 selects event 3", seen, 1);

    // R7: edges during a running delay are ignored and not counted.
    src_sel = 2'd1; edge_count = 3'd1; dly_en = 1'b1; dly_div = 2'd0; dly_val = 16'd10;
    do_reset(1, 1'b1);
    seen = 0;
    do_edge(1, 1'b1, seen);
    do_edge(1, 1'b1, seen);
    do_edge(1, 1'b1, seen);
    idle(12, seen);
    chk(seen == 1, "R7 one pulse despite edge during delay", seen, 1);
    seen = 0;
    do_edge(1, 1'b1, seen);
    idle(4, seen);
    chk(seen == 0, "R7 ignored edge was not counted", seen, 0);
    seen = 0;
    do_edge(1, 1'b1, seen);
    idle(12, seen);
    chk(seen == 1, "R3 tally restarted after pulse", seen, 1);

    // Sweep of the small configuration space.
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 2; f++)
        for (int n = 0; n < 3; n++)
          for (int en = 0; en < 2; en++)
            for (int dv = 0; dv < 4; dv++)
              for (int vi = 0; vi < 4; vi++)
                run_case(s, f, n, en, dv, vals[vi]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule